// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block computes, on every clock of the PLL domain, a 32-bit frequency-control word for a spread-spectrum clock synthesiser. An internal ramp climbs by a programmable step on each clock for one half of the modulation period. It then descends by the same step for the other half. Each half lasts a programmable base length plus a pseudo-random jitter term in units of 32 clocks. The jitter is drawn once per period from a 12-bit LFSR and limited by a programmable mask. A signed two's-complement centre offset is added to the ramp, and the sum is clamped into the unsigned 32-bit range.

A frequency-limit comparator raises a live status bit whenever the word is above a programmable ceiling. The same condition sets a sticky flag whether or not the interrupt is enabled. Software clears the flag by writing one to it. The control word is a continuous per-clock value that the divider samples every cycle, so it carries no valid/ready handshake and cannot be back-pressured. The register port is a plain single-cycle write strobe with a combinational read. It runs on the same clock as the word output.

Top module: `sscg_profile_top`

## Requirements
- R1: After reset the registers read: half-period base = PERIOD_RST, jitter mask = 0x03B, step = 0x000209D6, offset = 0, ceiling = 0xFFFFFFFF, enable = 0, flag = 0, status = 0. The ramp starts at 0 and rises, and freq_word reads 0.
- R2: During a rising half, the ramp grows by the step value on every clock and saturates at 0xFFFFFFFF.
- R3: During a falling half, the ramp shrinks by the step value on every clock and floors at 0.
- R4: Each half lasts L clocks, after which the direction flips; L = 0 behaves as L = 1. The first rising half after reset has L = PERIOD_RST.
- R5: When a falling half ends, the next period is drawn. Both of its halves use L = base + 32 × (lfsr & mask), where lfsr is the current value of a 12-bit Fibonacci LFSR (seed 0xACE). The LFSR then steps once: next = {lfsr[10:0], lfsr[11]^lfsr[5]^lfsr[3]^lfsr[0]}. Writes to the base or mask take effect only at that point.
- R6: freq_word = ramp + sign-extended offset, clamped to 0 when the sum is negative and to 0xFFFFFFFF when it is above that value.
- R7: Status (address 0x1C, bit 0) reads 1 exactly while freq_word > ceiling. Writes to 0x1C have no effect.
- R8: The flag (address 0x18, bit 0) becomes 1 on the clock edge after freq_word > ceiling, whatever the enable bit holds. Writing 1 to bit 0 clears it, and in the same cycle a clear beats a set. Writing 0 leaves it unchanged.
- R9: irq is 1 exactly when the flag and the enable bit (address 0x14, bit 0) are both 1.
- R10: The registers sit at these addresses: half-period base at 0x00 (PERIOD_W bits), jitter mask at 0x04 (12 bits), step at 0x08, offset at 0x0C, ceiling at 0x10, enable at 0x14 (1 bit). Unimplemented bits read as 0, and addresses not listed read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PLL-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| freq_word | output | 32 | Frequency-control word |
| irq | output | 1 | Frequency-limit interrupt |

## Verification
A software clear of the limit flag and a new limit detection can fall in the same clock edge. The bench forces this by programming an offset that keeps the word above the ceiling all the time. It then writes one to the flag with the interrupt enabled. The flag and irq must read 0 for exactly the cycle after the write and return to 1 on the following edge. A period boundary can coincide with a register write to the base or jitter mask. Here the cycle-accurate model judges that the old values are used at the edge of the write, and the new values only at the next boundary.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

  localparam logic [4:0] ADDR_HALF   = 5'h00;
  localparam logic [4:0] ADDR_JMASK  = 5'h04;
  localparam logic [4:0] ADDR_STEP   = 5'h08;
  localparam logic [4:0] ADDR_OFFS   = 5'h0C;
  localparam logic [4:0] ADDR_CEIL   = 5'h10;
  localparam logic [4:0] ADDR_IEN    = 5'h14;
  localparam logic [4:0] ADDR_FLAG   = 5'h18;
  localparam logic [4:0] ADDR_STATUS = 5'h1C;

  localparam int JIT_W = 12;

  typedef enum logic {
    DIR_FALL = 1'b0,
    DIR_RISE = 1'b1
  } ramp_dir_e;

  function automatic logic [31:0] add_clamp(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[32] ? 32'hFFFF_FFFF : s[31:0];
  endfunction

  function automatic logic [31:0] sub_floor(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : 32'd0;
  endfunction

endpackage

// File: rtl/sscg_regs.sv
module sscg_regs
  import sscg_pkg::*;
#(
  parameter int          PERIOD_W   = 24,
  parameter int          PERIOD_RST = 20000,
  parameter logic [11:0] JMASK_RST  = 12'h03B,
  parameter logic [31:0] STEP_RST   = 32'h0002_09D6,
  parameter logic [31:0] CEIL_RST   = 32'hFFFF_FFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [4:0]          addr,
  input  logic [31:0]         wdata,
  input  logic                limit,
  output logic [31:0]         rdata,
  output logic [PERIOD_W-1:0] half_base,
  output logic [JIT_W-1:0]    jit_mask,
  output logic [31:0]         step,
  output logic [31:0]         offset,
  output logic [31:0]         ceiling,
  output logic                ien,
  output logic                flag
);

  logic clr;
  assign clr = we && (addr == ADDR_FLAG) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_base <= PERIOD_W'(PERIOD_RST);
      jit_mask  <= JMASK_RST;
      step      <= STEP_RST;
      offset    <= 32'd0;
      ceiling   <= CEIL_RST;
      ien       <= 1'b0;
    end else if (we) begin
      case (addr)
        ADDR_HALF:  half_base <= wdata[PERIOD_W-1:0];
        ADDR_JMASK: jit_mask  <= wdata[JIT_W-1:0];
        ADDR_STEP:  step      <= wdata;
        ADDR_OFFS:  offset    <= wdata;
        ADDR_CEIL:  ceiling   <= wdata;
        ADDR_IEN:   ien       <= wdata[0];
        default:    ;
      endcase
    end
  end

  // sticky limit flag: clear beats set
  always_ff @(posedge clk) begin
    if (!rst_n)     flag <= 1'b0;
    else if (clr)   flag <= 1'b0;
    else if (limit) flag <= 1'b1;
  end

  always_comb begin
    rdata = 32'd0;
    case (addr)
      ADDR_HALF:   rdata = 32'(half_base);
      ADDR_JMASK:  rdata = 32'(jit_mask);
      ADDR_STEP:   rdata = step;
      ADDR_OFFS:   rdata = offset;
      ADDR_CEIL:   rdata = ceiling;
      ADDR_IEN:    rdata = {31'd0, ien};
      ADDR_FLAG:   rdata = {31'd0, flag};
      ADDR_STATUS: rdata = {31'd0, limit};
      default:     rdata = 32'd0;
    endcase
  end

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);

  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (limit && !clr) |=> flag);

  p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

endmodule

// File: rtl/sscg_jitter.sv
module sscg_jitter
  import sscg_pkg::*;
#(
  parameter logic [11:0] SEED = 12'hACE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [JIT_W-1:0] mask,
  output logic [JIT_W-1:0] jit
);

  logic [JIT_W-1:0] lfsr;
  logic             fb;

  assign fb  = lfsr[11] ^ lfsr[5] ^ lfsr[3] ^ lfsr[0];
  assign jit = lfsr & mask;

  always_ff @(posedge clk) begin
    if (!rst_n)       lfsr <= SEED;
    else if (advance) lfsr <= {lfsr[10:0], fb};
  end

  p_lfsr_alive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  p_lfsr_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(lfsr));

endmodule

// File: rtl/sscg_ramp.sv
module sscg_ramp
  import sscg_pkg::*;
#(
  parameter int PERIOD_W   = 24,
  parameter int PERIOD_RST = 20000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         step,
  input  logic [PERIOD_W-1:0] half_base,
  input  logic [JIT_W-1:0]    jit,
  output logic [31:0]         ramp,
  output logic                period_start
);

  // base + 32*jitter fits in one bit more than the wider of the two
  localparam int JSPAN_W = JIT_W + 5;
  localparam int HL_W    = ((PERIOD_W > JSPAN_W) ? PERIOD_W : JSPAN_W) + 1;

  ramp_dir_e        dir;
  logic [HL_W-1:0]  cnt;
  logic [HL_W-1:0]  half_len;
  logic             last;
  logic [HL_W-1:0]  next_len;

  assign last         = ({1'b0, cnt} + 1'b1) >= {1'b0, half_len};
  assign period_start = last && (dir == DIR_FALL);
  assign next_len     = HL_W'(half_base) + (HL_W'(jit) << 5);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ramp     <= 32'd0;
      dir      <= DIR_RISE;
      cnt      <= '0;
      half_len <= HL_W'(PERIOD_RST);
    end else begin
      ramp <= (dir == DIR_RISE) ? add_clamp(ramp, step) : sub_floor(ramp, step);
      if (last) begin
        cnt <= '0;
        if (dir == DIR_RISE) begin
          dir <= DIR_FALL;
        end else begin
          dir      <= DIR_RISE;
          half_len <= next_len;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_rise_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_RISE) |=> ramp >= $past(ramp));

  p_fall_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_FALL) |=> ramp <= $past(ramp));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < half_len) || (half_len == '0));

  p_dir_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> dir != $past(dir));

endmodule

// File: rtl/sscg_shaper.sv
module sscg_shaper (
  input  logic [31:0] ramp,
  input  logic [31:0] offset,
  input  logic [31:0] ceiling,
  output logic [31:0] word,
  output logic        limit
);

  logic signed [33:0] sum;

  assign sum = $signed({2'b00, ramp}) + $signed({{2{offset[31]}}, offset});

  always_comb begin
    if (sum[33])      word = 32'd0;
    else if (sum[32]) word = 32'hFFFF_FFFF;
    else              word = sum[31:0];
  end

  assign limit = word > ceiling;

endmodule

// File: rtl/sscg_profile_top.sv
module sscg_profile_top
  import sscg_pkg::*;
#(
  parameter int          PERIOD_W   = 24,
  parameter int          PERIOD_RST = 20000,
  parameter logic [11:0] JMASK_RST  = 12'h03B,
  parameter logic [31:0] STEP_RST   = 32'h0002_09D6,
  parameter logic [31:0] CEIL_RST   = 32'hFFFF_FFFF,
  parameter logic [11:0] LFSR_SEED  = 12'hACE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [31:0] freq_word,
  output logic        irq
);

  logic [PERIOD_W-1:0] half_base;
  logic [JIT_W-1:0]    jit_mask;
  logic [JIT_W-1:0]    jit;
  logic [31:0]         step;
  logic [31:0]         offset;
  logic [31:0]         ceiling;
  logic [31:0]         ramp;
  logic                ien;
  logic                flag;
  logic                limit;
  logic                period_start;

  sscg_regs #(
    .PERIOD_W  (PERIOD_W),
    .PERIOD_RST(PERIOD_RST),
    .JMASK_RST (JMASK_RST),
    .STEP_RST  (STEP_RST),
    .CEIL_RST  (CEIL_RST)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .limit    (limit),
    .rdata    (reg_rdata),
    .half_base(half_base),
    .jit_mask (jit_mask),
    .step     (step),
    .offset   (offset),
    .ceiling  (ceiling),
    .ien      (ien),
    .flag     (flag)
  );

  sscg_jitter #(
    .SEED(LFSR_SEED)
  ) u_jitter (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(period_start),
    .mask   (jit_mask),
    .jit    (jit)
  );

  sscg_ramp #(
    .PERIOD_W  (PERIOD_W),
    .PERIOD_RST(PERIOD_RST)
  ) u_ramp (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (step),
    .half_base   (half_base),
    .jit         (jit),
    .ramp        (ramp),
    .period_start(period_start)
  );

  sscg_shaper u_shaper (
    .ramp   (ramp),
    .offset (offset),
    .ceiling(ceiling),
    .word   (freq_word),
    .limit  (limit)
  );

  assign irq = flag & ien;

  p_offset_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !offset[31] |-> freq_word >= ramp);

  p_offset_ceil_r6: assert property (@(posedge clk) disable iff (!rst_n)
    offset[31] |-> freq_word <= ramp);

endmodule

// File: tb/test_sscg_profile_top.sv
module test_sscg_profile_top;

  localparam int TB_PERIOD_RST = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = 5'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [31:0] freq_word;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sscg_profile_top #(.PERIOD_RST(TB_PERIOD_RST)) i_sscg_profile_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .freq_word(freq_word), .irq(irq)
  );

  // behavioural reference
  longint    m_ramp, m_half, m_cnt, m_base, m_step, m_off, m_ceil;
  bit        m_up, m_ien, m_flag;
  bit [11:0] m_lfsr, m_mask;

  function automatic longint m_word();
    longint s;
    s = m_ramp + m_off;
    if (s < 0) return 0;
    if (s > 64'hFFFF_FFFF) return 64'hFFFF_FFFF;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ramp = 0; m_up = 1; m_cnt = 0; m_half = TB_PERIOD_RST;
      m_base = TB_PERIOD_RST; m_mask = 12'h03B; m_step = 32'h209D6;
      m_off = 0; m_ceil = 64'hFFFF_FFFF; m_ien = 0; m_flag = 0; m_lfsr = 12'hACE;
    end else begin
      bit lim, clr;
      lim = m_word() > m_ceil;
      clr = reg_we && reg_addr == 5'h18 && reg_wdata[0];
      if (clr) m_flag = 0; else if (lim) m_flag = 1;
      if (m_up) m_ramp = (m_ramp + m_step > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : m_ramp + m_step;
      else      m_ramp = (m_ramp > m_step) ? m_ramp - m_step : 0;
      if (m_cnt + 1 >= m_half) begin
        m_cnt = 0;
        if (m_up) m_up = 0;
        else begin
          m_up = 1;
          m_half = m_base + 32 * longint'(m_lfsr & m_mask);
          m_lfsr = {m_lfsr[10:0], m_lfsr[11] ^ m_lfsr[5] ^ m_lfsr[3] ^ m_lfsr[0]};
        end
      end else m_cnt++;
      if (reg_we) begin
        case (reg_addr)
          5'h00: m_base = longint'(reg_wdata[23:0]);
          5'h04: m_mask = reg_wdata[11:0];
          5'h08: m_step = longint'(reg_wdata);
          5'h0C: m_off  = longint'($signed(reg_wdata));
          5'h10: m_ceil = longint'(reg_wdata);
          5'h14: m_ien  = reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(freq_word == 32'(m_word()), "R6 freq_word (R2/R3 ramp)", freq_word, m_word());
      chk(irq == (m_flag & m_ien), "R9 irq", irq, m_flag & m_ien);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    #1 chk(freq_word == 0, "R1 freq_word at reset", freq_word, 0);
    // R1 reset register values
    rd(5'h00, d); chk(d == TB_PERIOD_RST, "R1 half base", d, TB_PERIOD_RST);
    rd(5'h04, d); chk(d == 32'h03B, "R1 jitter mask", d, 32'h03B);
    rd(5'h08, d); chk(d == 32'h209D6, "R1 step", d, 32'h209D6);
    rd(5'h0C, d); chk(d == 0, "R1 offset", d, 0);
    rd(5'h10, d); chk(d == 32'hFFFF_FFFF, "R1 ceiling", d, 32'hFFFF_FFFF);
    rd(5'h14, d); chk(d == 0, "R1 enable", d, 0);
    rd(5'h18, d); chk(d == 0, "R1 flag", d, 0);
    rd(5'h1C, d); chk(d == 0, "R1 status", d, 0);

    // R10 field widths and unmapped address
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); chk(d == 32'hFFF, "R10 jitter mask width", d, 32'hFFF);
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, d); chk(d == 32'hFF_FFFF, "R10 base width", d, 32'hFF_FFFF);
    rd(5'h1E, d); chk(d == 0, "R10 unmapped", d, 0);

    // R2 R3 R4 plain triangle, no jitter
    wr(5'h04, 32'h0);
    wr(5'h00, 32'd10);
    wr(5'h08, 32'd1000);
    run(200);
    // R4 zero-length halves
    wr(5'h00, 32'd0);
    run(60);
    // R5 jitter with small base, period changes mid-run
    wr(5'h00, 32'd6);
    wr(5'h04, 32'd3);
    run(700);
    wr(5'h04, 32'h0A5);
    run(2500);

    // R2 saturation at the top, R3 floor at zero
    wr(5'h04, 32'h0);
    wr(5'h00, 32'd8);
    wr(5'h08, 32'h4000_0000);
    run(120);

    // R6 negative offset clamps to zero, large positive offset clamps high
    wr(5'h08, 32'd5000);
    wr(5'h0C, 32'hFFFF_4000);
    run(80);
    wr(5'h0C, 32'h7FFF_FFFF);
    wr(5'h08, 32'h4000_0000);
    run(80);
    wr(5'h0C, 32'hEB85_1EB9);
    run(80);

    // R7 R8 limit with interrupt disabled
    wr(5'h08, 32'd1000);
    wr(5'h0C, 32'h0);
    wr(5'h10, 32'd5000);
    run(100);
    rd(5'h18, d); chk(d == 1, "R8 flag set while disabled", d, 1);
    chk(irq == 0, "R9 irq masked", irq, 0);
    rd(5'h1C, d); chk(d[0] == (m_word() > m_ceil), "R7 status live", d, m_word() > m_ceil);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h1C, d); chk(d[0] == (m_word() > m_ceil), "R7 status write ignored", d, m_word() > m_ceil);
    wr(5'h18, 32'h0);
    rd(5'h18, d); chk(d == 1, "R8 write zero keeps flag", d, 1);

    // R8 R9 clear racing a continuous set
    wr(5'h0C, 32'h0010_0000);
    wr(5'h10, 32'h100);
    wr(5'h14, 32'h1);
    run(4);
    chk(irq == 1, "R9 irq asserted", irq, 1);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = 5'h18; reg_wdata = 32'h1;
    @(posedge clk); #2;
    reg_we = 1'b0;
    #1 chk(reg_rdata == 0, "R8 clear wins", reg_rdata, 0);
    chk(irq == 0, "R8 irq drops after clear", irq, 0);
    @(posedge clk); #3;
    chk(reg_rdata == 1, "R8 flag resets next edge", reg_rdata, 1);
    // no limit: clear holds
    wr(5'h0C, 32'h0);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h18, 32'h1);
    run(40);
    rd(5'h18, d); chk(d == 0, "R8 cleared stays clear", d, 0);
    chk(irq == 0, "R9 irq low", irq, 0);
    run(20);
    finish_up();
  end

endmodule